// File: doc/BRIEF.md
# Bus Wake-Up Pattern Detector

This block sits in one channel of a bus transceiver. While the channel is in standby it watches the bus level that a low-power receiver has already sampled and reduced to dominant or recessive. It raises a wake flag once it sees a valid remote wake-up. A valid wake-up is a dominant phase, then a recessive phase, then a second dominant phase. Each phase must last a minimum number of clock cycles, and the recessive phase and the second dominant phase must finish inside an overall window. If the window runs out, the detector drops back to idle. When the channel is in normal mode, the receive-data pin simply mirrors the bus.

Two run-time inputs set the timing, both in clock cycles: `phase_min_i` is the minimum length of a phase and `wake_to_i` is the window. The window opens at the clock edge where the first dominant phase qualifies. The sequence machine has seven states:

- `ST_IDLE`: waits for dominant.
- `ST_DOM_A`: counts the first dominant phase.
- `ST_HOLD_A`: the first phase has qualified and the bus is still dominant.
- `ST_REC_B`: counts the recessive phase.
- `ST_REC_Q`: the recessive phase has qualified and the machine waits for dominant.
- `ST_DOM_C`: counts the second dominant phase.
- `ST_WOKE`: the wake-up has been detected.

The transitions are:

- **start**: `ST_IDLE` to `ST_DOM_A` when the bus is dominant.
- **qualify**: `ST_DOM_A` to `ST_HOLD_A`, `ST_REC_B` to `ST_REC_Q`, and `ST_DOM_C` to `ST_WOKE`.
- **edge**: `ST_HOLD_A` to `ST_REC_B` when the bus goes recessive, and `ST_REC_Q` to `ST_DOM_C` when it goes dominant.
- **glitch**: `ST_DOM_A` or `ST_DOM_C` to `ST_IDLE` when the bus goes recessive too early.
- **retry**: `ST_REC_B` to `ST_DOM_A` when the bus goes dominant too early.
- **expire**: any windowed state to `ST_IDLE`.
- **exit**: any state to `ST_IDLE` when standby is low.

Top module: `wkp_wake_detector`

## Requirements
- R1: With `standby_i` low, `rxd_o` is 0 while `bus_dom_i` is 1 (dominant) and 1 while it is 0 (recessive), in the same cycle, and `wake_o` stays 0 whatever the bus does.
- R2: A phase counts only after `phase_min_i` consecutive sampled edges at its level. `wake_o` rises at the clock edge that samples the `phase_min_i`-th dominant cycle of the second dominant phase.
- R3: Let the first dominant phase last D1 cycles and the recessive phase R cycles, both at least `phase_min_i`. A wake-up is reported only if D1 + R <= `wake_to_i`. Otherwise the window expires and the detector returns to idle.
- R4: A recessive glitch shorter than `phase_min_i` inside the first or the second dominant phase returns the detector to idle. A dominant glitch shorter than `phase_min_i` inside the recessive phase starts a new first dominant phase (retry).
- R5: In standby, before a wake-up is detected, `rxd_o` is held at 1.
- R6: Once a wake-up is detected, `wake_o` stays 1 for as long as standby is held, and `rxd_o` follows the bus (0 on dominant).
- R7: One clock edge with `standby_i` low clears `wake_o` and throws away any partial sequence, so that afterwards a complete new pattern is needed.
- R8: After reset `wake_o` is 0, the sequence is idle, and in standby `rxd_o` reads 1.
- R9: Correct operation needs `phase_min_i` >= 2 and `wake_to_i` > 3 * `phase_min_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | 1 = standby (detection on), 0 = normal mode |
| bus_dom_i | input | 1 | Sampled bus level, 1 = dominant, 0 = recessive |
| phase_min_i | input | CNT_W | Minimum phase length in cycles |
| wake_to_i | input | CNT_W | Window length in cycles, counted from first-phase qualification |
| wake_o | output | 1 | Wake-up detected |
| rxd_o | output | 1 | Receive-data pin level |

## Verification
The assertions assume that `bus_dom_i` and `standby_i` only change away from the sampling edge, and that the timing inputs obey R9 and are held steady for the whole run. The bench holds `phase_min_i` at 3 and `wake_to_i` at 12 throughout and drives every input on the falling edge.

The bench sweeps the lengths of the three phases. It keeps the first phase no longer than `phase_min_i` + `wake_to_i`, so that a timed-out phase cannot run on into a second, unintended pattern. Each pattern ends with a recessive tail longer than the window, which returns any partial sequence to idle.

// File: rtl/wkp_pkg.sv
package wkp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DOM_A  = 3'd1,
        ST_HOLD_A = 3'd2,
        ST_REC_B  = 3'd3,
        ST_REC_Q  = 3'd4,
        ST_DOM_C  = 3'd5,
        ST_WOKE   = 3'd6
    } wk_state_t;

endpackage

// File: rtl/wkp_phase_timer.sv
// Counts consecutive samples of the phase currently being qualified.
module wkp_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic             adv,
    input  logic [CNT_W-1:0] limit,
    output logic             reached
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_ONE;
        end else if (adv && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    // The sample taken at this edge is number cnt_q + 1 of the phase.
    assign reached = (cnt_q >= (limit - CNT_ONE));

endmodule

// File: rtl/wkp_window_timer.sv
// Counts the edges spent inside the wake-up window.
module wkp_window_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (clr || !run) begin
            win_q <= '0;
        end else if (!expired) begin
            win_q <= win_q + CNT_ONE;
        end
    end

    assign expired = run && (win_q >= (limit - CNT_ONE));

endmodule

// File: rtl/wkp_seq_fsm.sv
// Sequence machine: dominant, then recessive, then dominant.
module wkp_seq_fsm
    import wkp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      standby,
    input  logic      bus_dom,
    input  logic      ph_reached,
    input  logic      win_expired,
    output wk_state_t state,
    output logic      ph_clr,
    output logic      ph_load,
    output logic      ph_adv,
    output logic      win_run
);
    wk_state_t state_q, state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state, plus the phase-timer strobes that belong to each transition.
    always_comb begin
        state_d = state_q;
        ph_load = 1'b0;
        ph_adv  = 1'b0;
        if (!standby) begin
            state_d = ST_IDLE;                       // exit
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (bus_dom) begin
                        state_d = ST_DOM_A;          // start
                        ph_load = 1'b1;
                    end
                end
                ST_DOM_A: begin
                    if (!bus_dom) begin
                        state_d = ST_IDLE;           // glitch
                    end else if (ph_reached) begin
                        state_d = ST_HOLD_A;         // qualify
                    end else begin
                        ph_adv = 1'b1;
                    end
                end
                ST_HOLD_A: begin
                    if (win_expired) begin
                        state_d = ST_IDLE;           // expire
                    end else if (!bus_dom) begin
                        state_d = ST_REC_B;          // edge
                        ph_load = 1'b1;
                    end
                end
                ST_REC_B: begin
                    if (win_expired) begin
                        state_d = ST_IDLE;           // expire
                    end else if (bus_dom) begin
                        state_d = ST_DOM_A;          // retry
                        ph_load = 1'b1;
                    end else if (ph_reached) begin
                        state_d = ST_REC_Q;          // qualify
                    end else begin
                        ph_adv = 1'b1;
                    end
                end
                ST_REC_Q: begin
                    if (win_expired) begin
                        state_d = ST_IDLE;           // expire
                    end else if (bus_dom) begin
                        state_d = ST_DOM_C;          // edge
                        ph_load = 1'b1;
                    end
                end
                ST_DOM_C: begin
                    if (bus_dom && ph_reached) begin
                        state_d = ST_WOKE;           // qualify wins over expiry
                    end else if (win_expired || !bus_dom) begin
                        state_d = ST_IDLE;           // expire or glitch
                    end else begin
                        ph_adv = 1'b1;
                    end
                end
                ST_WOKE: begin
                    state_d = ST_WOKE;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // Outputs that depend on the state alone.
    always_comb begin
        ph_clr  = !standby;
        win_run = 1'b0;
        unique case (state_q)
            ST_HOLD_A, ST_REC_B, ST_REC_Q, ST_DOM_C: win_run = 1'b1;
            default:                                 win_run = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/wkp_wake_detector.sv
module wkp_wake_detector
    import wkp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_i,
    input  logic             bus_dom_i,
    input  logic [CNT_W-1:0] phase_min_i,
    input  logic [CNT_W-1:0] wake_to_i,
    output logic             wake_o,
    output logic             rxd_o
);
    wk_state_t state;
    logic      ph_clr, ph_load, ph_adv, ph_reached;
    logic      win_run, win_expired;

    wkp_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby     (standby_i),
        .bus_dom     (bus_dom_i),
        .ph_reached  (ph_reached),
        .win_expired (win_expired),
        .state       (state),
        .ph_clr      (ph_clr),
        .ph_load     (ph_load),
        .ph_adv      (ph_adv),
        .win_run     (win_run)
    );

    wkp_phase_timer #(.CNT_W(CNT_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ph_clr),
        .load    (ph_load),
        .adv     (ph_adv),
        .limit   (phase_min_i),
        .reached (ph_reached)
    );

    wkp_window_timer #(.CNT_W(CNT_W)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ph_clr),
        .run     (win_run),
        .limit   (wake_to_i),
        .expired (win_expired)
    );

    // Pin outputs.
    always_comb begin
        wake_o = (state == ST_WOKE);
        if (!standby_i || wake_o) begin
            rxd_o = !bus_dom_i;
        end else begin
            rxd_o = 1'b1;
        end
    end

endmodule

// File: rtl/wkp_wake_checker.sv
module wkp_wake_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             standby_i,
    input logic             bus_dom_i,
    input logic [CNT_W-1:0] phase_min_i,
    input logic             wake_o,
    input logic             rxd_o
);
    localparam logic [CNT_W-1:0] RUN_MAX = '1;

    logic [CNT_W-1:0] dom_run_q;

    // Length of the current dominant run, as seen at the pins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dom_run_q <= '0;
        end else if (!bus_dom_i) begin
            dom_run_q <= '0;
        end else if (dom_run_q != RUN_MAX) begin
            dom_run_q <= dom_run_q + CNT_W'(1);
        end
    end

    a_r1_follow_normal: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_i |-> (rxd_o != bus_dom_i));

    a_r7_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_i |=> !wake_o);

    a_r5_quiet_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_i && !wake_o) |-> rxd_o);

    a_r6_sticky_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && standby_i) |=> wake_o);

    a_r2_wake_on_dom: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> ($past(bus_dom_i) && $past(standby_i)));

    a_r2_min_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> (dom_run_q >= phase_min_i));

endmodule

bind wkp_wake_detector wkp_wake_checker #(.CNT_W(CNT_W)) u_wake_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby_i   (standby_i),
    .bus_dom_i   (bus_dom_i),
    .phase_min_i (phase_min_i),
    .wake_o      (wake_o),
    .rxd_o       (rxd_o)
);

// File: tb/wkp_wake_detector_tb_top.sv
module wkp_wake_detector_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CNT_W = 16;
    localparam int PMIN  = 3;   // R9: PMIN >= 2
    localparam int TWIN  = 12;  // R9: TWIN > 3*PMIN

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby = 1'b1;
    logic bus_dom = 1'b0;
    logic wake_o, rxd_o;

    int n_run = 0;
    int n_fail = 0;
    int rxd_err = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    wkp_wake_detector #(.CNT_W(CNT_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby_i   (standby),
        .bus_dom_i   (bus_dom),
        .phase_min_i (CNT_W'(PMIN)),
        .wake_to_i   (CNT_W'(TWIN)),
        .wake_o      (wake_o),
        .rxd_o       (rxd_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // One sample per cycle; pin rules R5/R6 tracked on every cycle.
    task automatic drive(input logic dom, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_dom = dom;
            @(posedge clk);
            #1;
            if (standby && !wake_o && rxd_o !== 1'b1) rxd_err++;
            if (standby && wake_o && rxd_o !== !dom) rxd_err++;
        end
    endtask

    task automatic restart();
        @(negedge clk);
        standby = 1'b0;
        bus_dom = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        standby = 1'b1;
        drive(1'b0, 2);
    endtask

    task automatic tail();
        drive(1'b0, TWIN + PMIN + 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        // R8: reset state
        chk(wake_o === 1'b0, "R8 wake after reset", int'(wake_o), 0);
        chk(rxd_o === 1'b1, "R8 rxd after reset", int'(rxd_o), 1);

        // R2: exact wake latency
        restart();
        drive(1'b1, PMIN);
        drive(1'b0, PMIN);
        drive(1'b1, PMIN - 1);
        chk(wake_o === 1'b0, "R2 one sample short", int'(wake_o), 0);
        drive(1'b1, 1);
        chk(wake_o === 1'b1, "R2 wake at last sample", int'(wake_o), 1);

        // R6: sticky and following
        drive(1'b1, 1);
        chk(rxd_o === 1'b0, "R6 rxd on dominant", int'(rxd_o), 0);
        drive(1'b0, 20);
        chk(rxd_o === 1'b1, "R6 rxd on recessive", int'(rxd_o), 1);
        chk(wake_o === 1'b1, "R6 wake held", int'(wake_o), 1);

        // R7: leaving standby clears the flag
        @(negedge clk);
        standby = 1'b0;
        @(posedge clk);
        #1;
        chk(wake_o === 1'b0, "R7 exit clears wake", int'(wake_o), 0);

        // R1: normal mode mirrors the bus and never wakes
        drive(1'b1, 1);
        chk(rxd_o === 1'b0, "R1 normal dominant", int'(rxd_o), 0);
        drive(1'b0, 1);
        chk(rxd_o === 1'b1, "R1 normal recessive", int'(rxd_o), 1);
        drive(1'b1, PMIN);
        drive(1'b0, PMIN);
        drive(1'b1, PMIN);
        chk(wake_o === 1'b0, "R1 no wake in normal", int'(wake_o), 0);

        // R4: short recessive restarts the first phase
        restart();
        drive(1'b1, PMIN);
        drive(1'b0, 1);
        drive(1'b1, PMIN);
        drive(1'b0, PMIN);
        drive(1'b1, PMIN);
        chk(wake_o === 1'b1, "R4 retry accepted", int'(wake_o), 1);

        // R4: glitch in second dominant returns to idle
        restart();
        drive(1'b1, PMIN);
        drive(1'b0, PMIN);
        drive(1'b1, PMIN - 1);
        drive(1'b0, 1);
        drive(1'b1, PMIN);
        tail();
        chk(wake_o === 1'b0, "R4 glitch in third phase", int'(wake_o), 0);

        // R7: leaving standby mid-sequence discards progress
        restart();
        drive(1'b1, PMIN);
        drive(1'b0, PMIN);
        @(negedge clk);
        standby = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        standby = 1'b1;
        drive(1'b1, PMIN);
        tail();
        chk(wake_o === 1'b0, "R7 partial sequence dropped", int'(wake_o), 0);

        // R3: window edges
        restart();
        drive(1'b1, PMIN);
        drive(1'b0, TWIN - PMIN);
        drive(1'b1, PMIN);
        chk(wake_o === 1'b1, "R3 window exactly met", int'(wake_o), 1);
        restart();
        drive(1'b1, PMIN);
        drive(1'b0, TWIN - PMIN + 1);
        drive(1'b1, PMIN);
        tail();
        chk(wake_o === 1'b0, "R3 window overrun", int'(wake_o), 0);

        // R2 R3 R4 R5: sweep of phase lengths
        for (int d1 = 1; d1 <= 8; d1++) begin
            for (int r = 1; r <= 8; r++) begin
                for (int d2 = 1; d2 <= 5; d2++) begin
                    bit exp_w;
                    exp_w = (d1 >= PMIN) && (r >= PMIN) && (d2 >= PMIN) && (d1 + r <= TWIN);
                    restart();
                    rxd_err = 0;
                    drive(1'b1, d1);
                    drive(1'b0, r);
                    drive(1'b1, d2);
                    tail();
                    chk(wake_o === exp_w, $sformatf("R3 sweep d1=%0d r=%0d d2=%0d", d1, r, d2),
                        int'(wake_o), int'(exp_w));
                    chk(rxd_err == 0, "R5 pin level in standby", rxd_err, 0);
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule